// File: doc/BRIEF.md
# Daisy-Chain Serial Write Controller

This block is the host-side master for a string of identical three-wire programmable resistor devices. Each device's serial output feeds the next device's input. One request carries a 3-bit channel address and an 8-bit wiper code for every device in the chain. The controller packs these into one long frame and pulls chip select low. It then shifts the whole frame out, one bit per serial clock, and releases chip select. On that rising edge of chip select, every device in the chain latches the word that has reached its own shift register.

The word for the device farthest from the controller goes out first, and the word for the nearest device goes out last. The serial clock idles low. Data changes only while the clock is low, and the devices sample it on the rising edge. A run-time divider setting stretches both clock phases, which allows for slow pulled-up chain nodes. A setting below the legal minimum is clamped to that minimum. A finite-state machine sequences the frame through six named states:

- `ST_IDLE`: chip select high, clock low. A valid request is accepted here and moves the machine to `ST_LEAD`.
- `ST_LEAD`: chip select low, clock low, first bit on the data line for one half period. It then moves to `ST_HIGH`.
- `ST_HIGH`: clock high for one half period. It moves to `ST_LOW` if bits remain, or to `ST_TAIL` after the last bit.
- `ST_LOW`: clock low with the next bit presented for one half period. It then moves back to `ST_HIGH`.
- `ST_TAIL`: clock low, chip select still low for one half period after the final falling edge. It then moves to `ST_GAP`.
- `ST_GAP`: chip select high for the enforced gap time. It then returns to `ST_IDLE`.

Top module: `dcw_chain_writer`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0 and req_ready is 1.
- R2: req_ready equals the inverse of busy. A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle, busy is 1 and cs_n is 0.
- R3: One frame has exactly NUM_DEV×11 rising sclk edges, and cs_n is 0 at every one of them.
- R4: The frame is sent device index NUM_DEV-1 first, down to device index 0 last. Each device word is its 3-bit address (req_addr[3i+2:3i]) MSB first, followed by its 8-bit code (req_code[8i+7:8i]) MSB first. The value of sdata at each sclk rise is the bit being sent.
- R5: sdata holds its value throughout every sclk high phase.
- R6: Every sclk high phase and every sclk low phase inside a frame lasts exactly H clock cycles. H = max(div_cfg, MIN_HALF), captured when the request is accepted. Changes to div_cfg during a frame have no effect on that frame.
- R7: cs_n falls H cycles before the first sclk rise. cs_n rises H cycles after the last sclk fall, with sclk low.
- R8: After cs_n rises, it stays high for GAP_CYC cycles before busy falls. Total busy time is H×(2×NUM_DEV×11+1)+GAP_CYC cycles.
- R9: A req_valid pulse while busy is 1 is ignored: no extra frame is sent.
- R10: sclk is 0 whenever cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | NUM_DEV*3 | Channel address per device, device i at bits [3i+2:3i] |
| req_code | input | NUM_DEV*8 | Wiper code per device, device i at bits [8i+7:8i] |
| div_cfg | input | DIV_W | Serial half-period in system cycles, clamped to MIN_HALF |
| busy | output | 1 | Frame or gap in progress |
| sclk | output | 1 | Serial clock to the chain, idles low |
| cs_n | output | 1 | Active-low chip select shared by the chain |
| sdata | output | 1 | Serial data to the nearest device |

## Verification
The bench builds the block with NUM_DEV=2, DIV_W=4, MIN_HALF=1 and GAP_CYC=2, which gives a 22-bit frame covering two devices. The narrow divider puts both the zero setting (clamped to one cycle) and the largest setting (15 cycles) within a short run. This lets the bench check frame timing at both extremes of the half period. Two words in the frame expose the farthest-first ordering. A divider change and a refused request are both injected while a frame is running.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    localparam int ADDR_W = 3;
    localparam int CODE_W = 8;
    localparam int WORD_W = ADDR_W + CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_HIGH = 3'd2,
        ST_LOW  = 3'd3,
        ST_TAIL = 3'd4,
        ST_GAP  = 3'd5
    } dcw_state_e;
endpackage

// File: rtl/dcw_pace.sv
// Phase timer: loaded on each state entry, flags the last cycle of a phase.
module dcw_pace #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             done
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dcw_shifter.sv
// Packs the per-device words farthest-first and shifts them out MSB first.
module dcw_shifter
    import dcw_pkg::*;
#(
    parameter int NUM_DEV = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      shift,
    input  logic [NUM_DEV*ADDR_W-1:0] addr_in,
    input  logic [NUM_DEV*CODE_W-1:0] code_in,
    output logic                      msb
);
    localparam int FRAME_W = NUM_DEV * WORD_W;

    logic [FRAME_W-1:0] packed_w;
    logic [FRAME_W-1:0] frame_q;

    // Device i occupies word slot i; the highest slot leaves first.
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_word
        assign packed_w[i*WORD_W +: WORD_W] =
            {addr_in[i*ADDR_W +: ADDR_W], code_in[i*CODE_W +: CODE_W]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= packed_w;
        end else if (shift) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign msb = frame_q[FRAME_W-1];
endmodule

// File: rtl/dcw_bitcount.sv
// Counts the bits still to be clocked after the current one.
module dcw_bitcount #(
    parameter int FRAME_W = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic last
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] START = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= START;
        end else if (step && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == '0);
endmodule

// File: rtl/dcw_chain_writer.sv
module dcw_chain_writer
    import dcw_pkg::*;
#(
    parameter int NUM_DEV  = 2,
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 1,
    parameter int GAP_CYC  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [NUM_DEV*ADDR_W-1:0] req_addr,
    input  logic [NUM_DEV*CODE_W-1:0] req_code,
    input  logic [DIV_W-1:0]          div_cfg,
    output logic                      busy,
    output logic                      sclk,
    output logic                      cs_n,
    output logic                      sdata
);
    localparam int FRAME_W = NUM_DEV * WORD_W;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);
    localparam int TMR_W   = (DIV_W > GAP_W) ? DIV_W : GAP_W;
    localparam logic [DIV_W-1:0] MIN_H   = DIV_W'(MIN_HALF);
    localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(GAP_CYC - 1);

    dcw_state_e       state_q, state_d;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] half_req;
    logic             accept;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             shift_en;
    logic             bits_last;
    logic             data_msb;
    logic             drive_data;

    // Clamp the requested half period to the legal minimum.
    assign half_req = (div_cfg < MIN_H) ? MIN_H : div_cfg;
    assign accept   = req_valid && req_ready;

    dcw_pace #(.TMR_W(TMR_W)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dcw_shifter #(.NUM_DEV(NUM_DEV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (shift_en),
        .addr_in (req_addr),
        .code_in (req_code),
        .msb     (data_msb)
    );

    dcw_bitcount #(.FRAME_W(FRAME_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (shift_en),
        .last  (bits_last)
    );

    // Transition logic.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(half_q) - 1'b1;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(half_req) - 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_done) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (bits_last) begin
                        state_d = ST_TAIL;
                    end else begin
                        state_d  = ST_LOW;
                        shift_en = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_TAIL: begin
                if (tmr_done) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LD;
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= MIN_H;
        end else begin
            state_q <= state_d;
            if (accept) begin
                half_q <= half_req;
            end
        end
    end

    // Output decode.
    always_comb begin
        cs_n       = 1'b1;
        sclk       = 1'b0;
        drive_data = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_LEAD: begin cs_n = 1'b0; drive_data = 1'b1; end
            ST_HIGH: begin cs_n = 1'b0; drive_data = 1'b1; sclk = 1'b1; end
            ST_LOW:  begin cs_n = 1'b0; drive_data = 1'b1; end
            ST_TAIL: cs_n = 1'b0;
            ST_GAP:  cs_n = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign sdata     = drive_data & data_msb;
    assign req_ready = !busy;
endmodule

// File: rtl/dcw_chain_writer_chk.sv
module dcw_chain_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic sclk,
    input logic cs_n,
    input logic sdata
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R10

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata)); // R5

    AST_READY_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == !busy); // R2

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !cs_n)); // R2

    AST_SELECT_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R8

    AST_RELEASE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sclk && !$past(sclk))); // R7
endmodule

bind dcw_chain_writer dcw_chain_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sdata     (sdata)
);

// File: tb/dcw_chain_writer_test.sv
module dcw_chain_writer_test;
    localparam int ND  = 2;
    localparam int DW  = 4;
    localparam int MH  = 1;
    localparam int GC  = 2;
    localparam int FW  = ND * 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ND*3-1:0] req_addr = '0;
    logic [ND*8-1:0] req_code = '0;
    logic [DW-1:0]   div_cfg = '0;
    logic busy, sclk, cs_n, sdata;

    int checks = 0;
    int errors = 0;
    int frames_done = 0;

    bit exp_q[$];
    int exp_half = 1;
    int exp_busy = 0;

    always #10 clk = ~clk;

    dcw_chain_writer #(.NUM_DEV(ND), .DIV_W(DW), .MIN_HALF(MH), .GAP_CYC(GC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_code(req_code), .div_cfg(div_cfg),
        .busy(busy), .sclk(sclk), .cs_n(cs_n), .sdata(sdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: event-driven comparison against the scoreboard queue.
    logic p_sclk = 1'b0, p_cs = 1'b1, p_busy = 1'b0;
    int hi_cnt = 0, lo_cnt = 0, bits = 0, gap_cnt = 0, busy_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && p_cs) begin
                lo_cnt = 1;
                bits = 0;
            end else if (sclk && !p_sclk) begin
                chk(cs_n == 1'b0, "R3 cs low at rise", cs_n, 0);
                if (bits == 0) chk(lo_cnt == exp_half, "R7 lead", lo_cnt, exp_half);
                else           chk(lo_cnt == exp_half, "R6 low phase", lo_cnt, exp_half);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected bit", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(sdata == e, "R4 bit value", sdata, e);
                end
                bits++;
                hi_cnt = 1;
            end else if (!sclk && p_sclk) begin
                chk(hi_cnt == exp_half, "R6 high phase", hi_cnt, exp_half);
                lo_cnt = 1;
            end else if (sclk) begin
                hi_cnt++;
            end else if (!cs_n) begin
                lo_cnt++;
            end

            if (cs_n && !p_cs) begin
                chk(lo_cnt == exp_half, "R7 tail", lo_cnt, exp_half);
                chk(bits == FW, "R3 bit count", bits, FW);
                chk(sclk == 1'b0, "R10 clock idle", sclk, 0);
                gap_cnt = 1;
            end else if (cs_n && busy) begin
                gap_cnt++;
            end

            if (busy && !p_busy) begin
                busy_cnt = 1;
            end else if (busy) begin
                busy_cnt++;
            end else if (!busy && p_busy) begin
                chk(busy_cnt == exp_busy, "R8 busy length", busy_cnt, exp_busy);
                chk(gap_cnt == GC, "R8 gap length", gap_cnt, GC);
                chk(req_ready == 1'b1, "R2 ready after frame", req_ready, 1);
                frames_done++;
            end
            p_sclk = sclk;
            p_cs = cs_n;
            p_busy = busy;
        end
    end

    // Driver: issue one request and push its expected bits.
    task automatic send(input logic [ND*3-1:0] a, input logic [ND*8-1:0] c,
                        input int dv, input bit disturb);
        int h;
        int start;
        while (!req_ready) @(negedge clk);
        h = (dv < MH) ? MH : dv;
        exp_half = h;
        exp_busy = h * (2 * FW + 1) + GC;
        for (int d = ND - 1; d >= 0; d--) begin
            for (int b = 2; b >= 0; b--) exp_q.push_back(a[d*3 + b]);
            for (int b = 7; b >= 0; b--) exp_q.push_back(c[d*8 + b]);
        end
        start = frames_done;
        req_addr = a;
        req_code = c;
        div_cfg = DW'(dv);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && cs_n == 1'b0, "R2 accept", busy, 1);
        chk(req_ready == 1'b0, "R2 ready while busy", req_ready, 0);
        if (disturb) begin
            repeat (5) @(negedge clk);
            div_cfg = DW'(dv + 4);   // R6: must not alter this frame
            req_addr = ~a;
            req_code = ~c;
            req_valid = 1'b1;        // R9: refused while busy
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (frames_done == start) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all bits seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R10 idle", sclk, 0);

        send({3'd5, 3'd2}, {8'hA5, 8'h3C}, 0, 1'b0);   // zero divider clamps
        send({3'd1, 3'd6}, {8'h81, 8'h7E}, 3, 1'b1);   // R6 and R9 disturbances
        repeat (8) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R9 no extra frame", busy, 0);
        send({3'd7, 3'd7}, {8'hFF, 8'hFF}, 1, 1'b0);
        send({3'd0, 3'd0}, {8'h00, 8'h01}, 15, 1'b0);  // largest divider
        send({3'd4, 3'd3}, {8'h55, 8'hAA}, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule